// File: doc/BRIEF.md
# UART Modem Status and Loopback

This block sits beside a 16550-style serial port and handles its modem handshake lines. It drives four active-low control outputs (data-terminal-ready, request-to-send and two general-purpose lines) from a 5-bit control value. It reports an 8-bit status byte. The upper nibble of the status byte gives the present level of the four incoming handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The lower nibble holds sticky change flags, which clear when software reads the status byte.

Bit 4 of the control value selects a loopback mode, used for self-test. In loopback the control bits are routed internally onto the status levels, the external control outputs rest at their inactive high level, and the external handshake pins are ignored. The incoming pins pass through a two-stage synchronizer before any edge is detected. A single output reports whether any change flag is set, for use by interrupt logic elsewhere.

Top module: `uart_modem_status`

## Requirements
- R1: With control bit 4 clear, `dtr_n_o`, `rts_n_o`, `out1_n_o` and `out2_n_o` are the complements of control bits 0, 1, 2 and 3 respectively, combinationally.
- R2: With control bit 4 set (loopback), all four control outputs are 1 whatever control bits 3:0 hold.
- R3: Outside loopback, status bits 4, 5, 6 and 7 equal the complements of `cts_n_i`, `dsr_n_i`, `ri_n_i` and `dcd_n_i`. A pin value sampled at clock edge k appears after edge k+2.
- R4: In loopback, status bit 4 takes control bit 1, bit 5 takes control bit 0, bit 6 takes control bit 2 and bit 7 takes control bit 3, after the next clock edge. The external pins have no effect.
- R5: Status bits 0, 1 and 3 set on the edge where status bit 4, 5 or 7 respectively changes value, in either direction.
- R6: Status bit 2 sets only on the edge where status bit 6 goes from 1 to 0, which is the ring pin rising. A falling ring pin does not set it.
- R7: When `stat_rd_i` is high at an edge, status bits 3:0 are cleared by that edge, and set bits otherwise hold.
- R8: A change that qualifies under R5 or R6 on the same edge as a read leaves its flag set.
- R9: `delta_any_o` is 1 exactly when any of status bits 3:0 is 1.
- R10: While `rst_n` is low, the status byte is 0 and `delta_any_o` is 0. Leaving reset with all pins high produces no change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| ctrl_i | input | 5 | Control value: bits 3:0 output requests, bit 4 loopback |
| stat_rd_i | input | 1 | One-cycle strobe marking a read of the status byte |
| dtr_n_o | output | 1 | Data-terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| out1_n_o | output | 1 | General output 1, active low |
| out2_n_o | output | 1 | General output 2, active low |
| stat_o | output | 8 | Status: 7:4 line levels, 3:0 change flags |
| delta_any_o | output | 1 | OR of the change flags |

## Verification
A wrong stored level in the upper nibble shows on `stat_o` at once. It also corrupts the next change flag: either a spurious flag appears, or a real transition is missed when the pin next moves. A flag register that clears without a read, or survives a read, differs from the reference on the very next edge. This holds because the comparison is made every cycle on the full status byte and the four outputs. Ring-edge polarity and the read/change collision are exercised with directed sequences, then under randomized pins, control and reads, both in and out of loopback.

// File: rtl/uart_modem_status.sv
module uart_modem_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic [4:0] ctrl_i,
  input  logic       stat_rd_i,
  output logic       dtr_n_o,
  output logic       rts_n_o,
  output logic       out1_n_o,
  output logic       out2_n_o,
  output logic [7:0] stat_o,
  output logic       delta_any_o
);
  localparam int NPIN = 4;
  localparam int SW   = SYNC_STAGES * NPIN;

  logic [SW-1:0]   sync_q;
  logic [NPIN-1:0] pins_n, synced_n;
  logic [NPIN-1:0] lvl_d, lvl_q;
  logic [NPIN-1:0] set_v, delta_d, delta_q;
  logic            loop;

  assign loop   = ctrl_i[4];
  assign pins_n = {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SW-NPIN-1:0], pins_n};

  assign synced_n = sync_q[SW-1 -: NPIN];

  assign lvl_d = loop ? {ctrl_i[3], ctrl_i[2], ctrl_i[0], ctrl_i[1]} : ~synced_n;

  assign set_v[0] = lvl_d[0] ^ lvl_q[0];
  assign set_v[1] = lvl_d[1] ^ lvl_q[1];
  assign set_v[2] = lvl_q[2] & ~lvl_d[2];
  assign set_v[3] = lvl_d[3] ^ lvl_q[3];

  assign delta_d = (stat_rd_i ? '0 : delta_q) | set_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_d;
      delta_q <= delta_d;
    end

  assign dtr_n_o     = loop | ~ctrl_i[0];
  assign rts_n_o     = loop | ~ctrl_i[1];
  assign out1_n_o    = loop | ~ctrl_i[2];
  assign out2_n_o    = loop | ~ctrl_i[3];
  assign stat_o      = {lvl_q, delta_q};
  assign delta_any_o = |delta_q;
endmodule

// File: rtl/uart_modem_status_chk.sv
module uart_modem_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ctrl_i,
  input logic       stat_rd_i,
  input logic       dtr_n_o,
  input logic       rts_n_o,
  input logic       out1_n_o,
  input logic       out2_n_o,
  input logic [7:0] stat_o,
  input logic       delta_any_o
);
  a_r1_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[4] |-> ({out2_n_o, out1_n_o, rts_n_o, dtr_n_o} == ~ctrl_i[3:0]));

  a_r2_loop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i[4] |-> (dtr_n_o && rts_n_o && out1_n_o && out2_n_o));

  a_r5_cts_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[0]) |-> (stat_o[4] != $past(stat_o[4])));

  a_r6_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[2]) |-> ($past(stat_o[6]) && !stat_o[6]));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((stat_o[3:0] & $past(stat_o[3:0])) == $past(stat_o[3:0])));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i ##1 $stable(stat_o[7:4]) |-> (stat_o[3:0] == 4'h0));

  a_r9_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    delta_any_o == (stat_o[3:0] != 4'h0));
endmodule

bind uart_modem_status uart_modem_status_chk chk_i (.*);

// File: tb/uart_modem_status_tb_top.sv
module uart_modem_status_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic cts_n, dsr_n, ri_n, dcd_n;
  logic [4:0] ctrl;
  logic rd;
  logic dtr_n, rts_n, o1_n, o2_n, dany;
  logic [7:0] stat;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_modem_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
    .ctrl_i(ctrl), .stat_rd_i(rd),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .out1_n_o(o1_n), .out2_n_o(o2_n),
    .stat_o(stat), .delta_any_o(dany)
  );

  // Behavioural reference: pin history queue, level and flag integers
  logic [3:0] hist[$];
  logic [3:0] m_lvl, m_flag;
  bit m_rd_last;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      hist.push_back(4'hF);
      hist.push_back(4'hF);
      m_lvl = 4'h0; m_flag = 4'h0; m_rd_last = 0;
    end else begin
      logic [3:0] old_pins, nl, fl;
      old_pins = hist.pop_front();
      hist.push_back({dcd_n, ri_n, dsr_n, cts_n});
      if (ctrl[4]) nl = {ctrl[3], ctrl[2], ctrl[0], ctrl[1]};
      else         nl = ~old_pins;
      fl = rd ? 4'h0 : m_flag;
      if (nl[0] != m_lvl[0]) fl[0] = 1'b1;
      if (nl[1] != m_lvl[1]) fl[1] = 1'b1;
      if (m_lvl[2] == 1'b1 && nl[2] == 1'b0) fl[2] = 1'b1;
      if (nl[3] != m_lvl[3]) fl[3] = 1'b1;
      m_lvl = nl; m_flag = fl; m_rd_last = rd;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [3:0] exp_o;
      exp_o = ctrl[4] ? 4'hF : ~ctrl[3:0];
      vectors++;
      if ({o2_n, o1_n, rts_n, dtr_n} !== exp_o) begin
        fails++;
        $display("FAIL %s outputs act=%h exp=%h", ctrl[4] ? "R2" : "R1",
                 {o2_n, o1_n, rts_n, dtr_n}, exp_o);
      end
      if (stat[7:4] !== m_lvl) begin
        fails++;
        $display("FAIL %s levels act=%h exp=%h", ctrl[4] ? "R4" : "R3", stat[7:4], m_lvl);
      end
      if (stat[3:0] !== m_flag) begin
        fails++;
        $display("FAIL %s flags act=%h exp=%h",
                 m_rd_last ? "R7 R8" : "R5 R6", stat[3:0], m_flag);
      end
      if (dany !== (m_flag != 4'h0)) begin
        fails++;
        $display("FAIL R9 any act=%b exp=%b", dany, m_flag != 4'h0);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    end
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    rst_n = 0; cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1; ctrl = 5'h00; rd = 0;
    tick(3);
    // R10: reset state
    vectors++;
    if (stat !== 8'h00 || dany !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset act=%h/%b exp=00/0", stat, dany);
    end
    rst_n = 1;
    tick(4);
    // R1: every output pattern outside loopback
    for (int c = 0; c < 16; c++) begin ctrl = 5'(c); tick(1); end
    ctrl = 5'h00;
    // R3 R5: each line asserted
    cts_n = 0; tick(4); rd = 1; tick(1); rd = 0;
    dsr_n = 0; tick(4);
    dcd_n = 0; tick(4);
    // R6: ring asserted (no flag), then released (flag)
    ri_n = 0;  tick(4);
    rd = 1; tick(1); rd = 0; tick(1);
    ri_n = 1;  tick(4);
    rd = 1; tick(1); rd = 0; tick(2);
    // R8: read lands on the edge where the change appears
    cts_n = 1; tick(2); rd = 1; tick(1); rd = 0; tick(3);
    ri_n = 0; tick(3); ri_n = 1; tick(2); rd = 1; tick(1); rd = 0; tick(3);
    // R4 R2: loopback, pins toggling and ignored
    for (int c = 0; c < 32; c++) begin
      ctrl = 5'h10 | 5'(c % 16);
      {dcd_n, ri_n, dsr_n, cts_n} = 4'(c * 5);
      rd = (c % 7 == 3);
      tick(1);
    end
    rd = 0; ctrl = 5'h00; tick(4);
    // Mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      {dcd_n, ri_n, dsr_n, cts_n} = r[3:0];
      ctrl = (i < 300) ? {1'b0, r[7:4]} : r[8:4];
      rd = (r[15:12] == 4'h0);
      tick(1);
    end
    rd = 0; tick(3);
    summary();
  end
endmodule